// File: doc/BRIEF.md
# Three-Wire Serial Control Register Write Port

This block accepts register writes from a host over a three-wire control bus: an active-low select, a serial clock, and a serial data line. The host changes data on the falling clock edge. The block samples it on the rising edge. Each transaction carries a 16-bit frame, most significant bit first. The block checks the frame's length, device address and direction, then writes one byte into a bank of up to 32 eight-bit control registers. It never drives data back to the host.

All three bus lines are oversampled by a faster system clock. They pass through a two-stage synchronizer, and edges are detected in the system domain. The system clock must run at least four times faster than the serial clock, which has a maximum rate of 5 MHz. The register contents appear on a flat output bus for neighbouring logic.

An active-low power-down input returns every register to its default value and blocks writes. A master-clock-present flag also blocks writes. One register bit acts as a soft run control for downstream timing logic. Clearing that bit leaves the other registers untouched.

Top module: `serial_regfile_wr`

## Requirements
- R1: A frame is 16 bits shifted in MSB first, one bit per rising edge of `sclk`. Bit 15 and bit 14 hold the device address. Bit 13 is the direction bit. Bits 12..8 hold the register index. Bits 7..0 hold the data byte.
- R2: No register changes while `csn` stays low. This holds even after all 16 bits have arrived. The write is applied only when `csn` returns high.
- R3: A frame commits only if exactly 16 rising `sclk` edges occurred while `csn` was low. With 15 or fewer edges, or 17 or more, every register keeps its value.
- R4: A frame whose direction bit is 0 is ignored.
- R5: A frame whose device address differs from the `chip_id` strap inputs is ignored.
- R6: A frame whose register index is `NREG` or higher is ignored.
- R7: While `pdn_n` is low, or while `rst` is high, every register holds its default value. Register 0 defaults to 8'h01. Register 1 defaults to 8'hFF. All other registers default to 8'h00. Frames received while `pdn_n` is low have no effect.
- R8: While `mclk_ok` is low, a frame that would otherwise commit is discarded.
- R9: `timing_run` equals bit 0 of register `RUN_ADDR`, which is 0 by default. Writing that register changes no other register.
- R10: Holding `csn` high clears the partial frame. A cut-short transaction therefore does not affect the next complete frame.
- R11: A committed byte is visible on `regs_flat` no later than 4 `clk` cycles after `csn` rises at the input.
- R12: Register i occupies bits [8i+7:8i] of `regs_flat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| pdn_n | input | 1 | Active-low power-down; forces defaults and blocks writes |
| mclk_ok | input | 1 | High when the master clock is present; low blocks writes |
| chip_id | input | 2 | Device address straps |
| csn | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| regs_flat | output | NREG*8 | All control registers, register i at bits [8i+7:8i] |
| timing_run | output | 1 | Soft run control, bit 0 of register RUN_ADDR |

## Verification
The bench builds the block with `NREG` = 24 and `RUN_ADDR` = 0. With 24 registers, the 5-bit index field can name registers 24 to 31, which do not exist, so the out-of-range discard path is exercised. The soft run bit sits in register 0, whose default is non-zero. This lets one write show both the `timing_run` change and that the other registers, including register 1 with its 8'hFF default, are left alone. The serial clock runs at one eighth of the system clock, which keeps the synchronizer inside its required rate ratio.

// File: rtl/swr_pkg.sv
package swr_pkg;

    localparam int CHIP_W  = 2;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = CHIP_W + 1 + ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    // Frame layout, first bit on the wire is the MSB of this struct.
    typedef struct packed {
        logic [CHIP_W-1:0] chip;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    // Write request from the frame decoder to the register bank.
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wreq_t;

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h01;
            1:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/swr_frame.sv
module swr_frame
    import swr_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_csn,
    input  logic              s_sclk,
    input  logic              s_sdi,
    input  logic [CHIP_W-1:0] chip_id,
    input  logic              wr_allow,
    output wreq_t             wreq
);

    localparam logic [ADDR_W:0] NREG_L = (ADDR_W + 1)'(NREG);

    logic               sclk_d;
    logic               csn_d;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] sh;
    frame_t             f;
    logic               sclk_rise;
    logic               cs_rise;
    logic               frame_ok;

    assign sclk_rise = s_sclk & ~sclk_d & ~s_csn;
    assign cs_rise   = s_csn & ~csn_d;
    assign f         = frame_t'(sh);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
            cnt    <= '0;
            sh     <= '0;
        end else begin
            sclk_d <= s_sclk;
            csn_d  <= s_csn;
            if (s_csn) begin
                cnt <= '0;
                sh  <= '0;
            end else if (sclk_rise) begin
                sh <= {sh[FRAME_W-2:0], s_sdi};
                if (cnt != CNT_SAT) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign frame_ok = (cnt == CNT_FULL) && f.wr && (f.chip == chip_id)
                      && ({1'b0, f.addr} < NREG_L);

    always_comb begin
        wreq.en   = cs_rise & frame_ok & wr_allow;
        wreq.addr = f.addr;
        wreq.data = f.data;
    end

    // Each sampled edge below saturation advances the count by one (R1)
    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && cnt != CNT_SAT) |=> (cnt == $past(cnt) + 1'b1));

    // Overlong frames stay flagged and never wrap back (R3)
    p_sat_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_SAT && !s_csn) |=> (cnt == CNT_SAT));

    // Idle select leaves no partial frame behind (R10)
    p_idle_clear_r10: assert property (@(posedge clk) disable iff (rst)
        s_csn |=> (cnt == '0 && sh == '0));

endmodule

// File: rtl/swr_regbank.sv
module swr_regbank
    import swr_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int RUN_ADDR = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pdn_n,
    input  wreq_t                  wreq,
    output logic [NREG*DATA_W-1:0] regs_flat,
    output logic                   timing_run
);

    function automatic logic [NREG*DATA_W-1:0] all_defaults();
        logic [NREG*DATA_W-1:0] v;
        for (int i = 0; i < NREG; i++) begin
            v[i*DATA_W +: DATA_W] = reg_default(i);
        end
        return v;
    endfunction

    localparam logic [NREG*DATA_W-1:0] DEF_FLAT = all_defaults();

    function automatic logic [DATA_W-1:0] byte_at(input logic [NREG*DATA_W-1:0] v,
                                                  input logic [ADDR_W-1:0]      a);
        int idx;
        idx = int'(a) % NREG;
        return v[idx*DATA_W +: DATA_W];
    endfunction

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst || !pdn_n) begin
                regs_flat[g*DATA_W +: DATA_W] <= reg_default(g);
            end else if (wreq.en && wreq.addr == ADDR_W'(g)) begin
                regs_flat[g*DATA_W +: DATA_W] <= wreq.data;
            end
        end
    end

    assign timing_run = regs_flat[RUN_ADDR*DATA_W];

    // Without a write request, the bank holds its contents (R2)
    p_hold_r2: assert property (@(posedge clk) disable iff (rst || !pdn_n)
        !wreq.en |=> $stable(regs_flat));

    // An accepted request lands in the addressed byte (R1)
    p_write_lands_r1: assert property (@(posedge clk) disable iff (rst || !pdn_n)
        wreq.en |=> (byte_at(regs_flat, $past(wreq.addr)) == $past(wreq.data)));

    // Power-down forces defaults (R7)
    p_defaults_r7: assert property (@(posedge clk) disable iff (rst)
        !pdn_n |=> (regs_flat == DEF_FLAT));

endmodule

// File: rtl/serial_regfile_wr.sv
module serial_regfile_wr
    import swr_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int RUN_ADDR = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pdn_n,
    input  logic                   mclk_ok,
    input  logic [CHIP_W-1:0]      chip_id,
    input  logic                   csn,
    input  logic                   sclk,
    input  logic                   sdi,
    output logic [NREG*DATA_W-1:0] regs_flat,
    output logic                   timing_run
);

    logic [2:0] raw_bus;
    logic [2:0] sync_bus;
    wreq_t      wreq;
    logic       wr_allow;

    assign raw_bus  = {csn, sclk, sdi};
    assign wr_allow = pdn_n & mclk_ok;

    swr_sync #(
        .W       (3),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_bus),
        .q   (sync_bus)
    );

    swr_frame #(
        .NREG (NREG)
    ) u_frame (
        .clk      (clk),
        .rst      (rst),
        .s_csn    (sync_bus[2]),
        .s_sclk   (sync_bus[1]),
        .s_sdi    (sync_bus[0]),
        .chip_id  (chip_id),
        .wr_allow (wr_allow),
        .wreq     (wreq)
    );

    swr_regbank #(
        .NREG     (NREG),
        .RUN_ADDR (RUN_ADDR)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .pdn_n      (pdn_n),
        .wreq       (wreq),
        .regs_flat  (regs_flat),
        .timing_run (timing_run)
    );

    // Writes never land while the clock flag is low (R8)
    p_no_write_without_clk_r8: assert property (@(posedge clk) disable iff (rst || !pdn_n)
        !mclk_ok |=> $stable(regs_flat));

endmodule

// File: tb/sim_serial_regfile_wr.sv
`timescale 1ns/1ps
module sim_serial_regfile_wr;

    localparam int         NR = 24;
    localparam logic [1:0] ID = 2'b10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pdn_n = 1'b1;
    logic          mclk_ok = 1'b1;
    logic [1:0]    chip_id = ID;
    logic          csn = 1'b1;
    logic          sclk = 1'b0;
    logic          sdi = 1'b0;
    logic [NR*8-1:0] regs_flat;
    logic          timing_run;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [NR];

    always #2.5 clk = ~clk;

    serial_regfile_wr #(.NREG(NR), .RUN_ADDR(0)) u0 (
        .clk(clk), .rst(rst), .pdn_n(pdn_n), .mclk_ok(mclk_ok), .chip_id(chip_id),
        .csn(csn), .sclk(sclk), .sdi(sdi), .regs_flat(regs_flat), .timing_run(timing_run)
    );

    function automatic logic [7:0] dflt(input int i);
        return (i == 0) ? 8'h01 : (i == 1) ? 8'hFF : 8'h00;
    endfunction

    function automatic logic [NR*8-1:0] model_flat();
        logic [NR*8-1:0] v;
        for (int i = 0; i < NR; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NR; i++) model[i] = dflt(i);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic chk(input string req, input logic [NR*8-1:0] act, input logic [NR*8-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Sends nbits clocks of the frame; extra bits beyond 16 are zero.
    task automatic send(input string req, input logic [1:0] chip, input logic w,
                        input logic [4:0] a, input logic [7:0] d, input int nbits,
                        input bit mid_check);
        logic [15:0] fr;
        fr = {chip, w, a, d};
        @(negedge clk) csn = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? fr[15-i] : 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (6) @(negedge clk);
        if (mid_check) chk("R2 before select release", regs_flat, model_flat());
        csn = 1'b1;
        if (nbits == 16 && chip == ID && w && int'(a) < NR && pdn_n && mclk_ok)
            model[a] = d;
        repeat (4) @(negedge clk);
        chk(req, regs_flat, model_flat());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20231));
        model_reset();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 reset defaults", regs_flat, model_flat());
        chk1("R9 default run bit", timing_run, 1'b1);

        send("R1 basic write", ID, 1'b1, 5'd5, 8'hA5, 16, 1'b1);
        send("R11 latency write", ID, 1'b1, 5'd2, 8'h5A, 16, 1'b0);
        send("R12 top register", ID, 1'b1, 5'd23, 8'h3C, 16, 1'b0);
        chk("R12 byte placement", {{(NR*8-8){1'b0}}, regs_flat[23*8 +: 8]},
            {{(NR*8-8){1'b0}}, 8'h3C});
        send("R3 short 15", ID, 1'b1, 5'd5, 8'h11, 15, 1'b0);
        send("R3 long 17", ID, 1'b1, 5'd5, 8'h22, 17, 1'b0);
        send("R3 long 20", ID, 1'b1, 5'd5, 8'h33, 20, 1'b0);
        send("R4 read bit", ID, 1'b0, 5'd5, 8'h44, 16, 1'b0);
        send("R5 wrong chip", 2'b01, 1'b1, 5'd5, 8'h55, 16, 1'b0);
        send("R6 index 24", ID, 1'b1, 5'd24, 8'h66, 16, 1'b0);
        send("R6 index 31", ID, 1'b1, 5'd31, 8'h77, 16, 1'b0);
        mclk_ok = 1'b0;
        send("R8 clock absent", ID, 1'b1, 5'd5, 8'h88, 16, 1'b0);
        mclk_ok = 1'b1;
        send("R9 clear run bit", ID, 1'b1, 5'd0, 8'h00, 16, 1'b0);
        chk1("R9 run output low", timing_run, 1'b0);
        send("R10 aborted frame", ID, 1'b1, 5'd7, 8'h99, 5, 1'b0);
        send("R10 next frame", ID, 1'b1, 5'd7, 8'hC3, 16, 1'b0);

        @(negedge clk) pdn_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        chk("R7 power-down defaults", regs_flat, model_flat());
        send("R7 write during power-down", ID, 1'b1, 5'd4, 8'hEE, 16, 1'b0);
        pdn_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 after power-up", regs_flat, model_flat());

        for (int n = 0; n < 150; n++) begin
            logic [1:0] c;
            logic       w;
            int         nb;
            int         pick;
            c    = ($urandom_range(0, 4) != 0) ? ID : 2'($urandom_range(0, 3));
            w    = ($urandom_range(0, 6) != 0);
            pick = $urandom_range(0, 5);
            nb   = (pick == 0) ? 15 : (pick == 1) ? 17 : 16;
            mclk_ok = ($urandom_range(0, 9) != 0);
            send("R1 random frame", c, w, 5'($urandom_range(0, 31)),
                 8'($urandom_range(0, 255)), nb, 1'b0);
            chk1("R9 random run bit", timing_run, model[0][0]);
        end
        mclk_ok = 1'b1;
        summary();
    end

endmodule